// File: doc/BRIEF.md
# Addressable Scan Port Switch

This block joins a multidrop primary JTAG test access port, shared by many boards on a backplane, to the single test port of one board. A board is joined only when a tester addresses it in-band over the primary data input. The block follows the primary TAP state machine. While that machine rests in a stable non-shift state, the block receives a serial address coded as bit-pairs. It compares the address with a strapped board address and, on a match, echoes its own address back on the primary data output before it connects. Three reserved addresses act on every port at once: one disconnects, one resets and one connects in listen-only multicast mode.

When the port is connected, the forward and return paths are plain combinational wires, so board-level vectors run unchanged. The test clock and test reset always pass straight through. The tri-state behaviour of both data outputs is given as explicit enable outputs. An active-low bypass input forces the connection regardless of reset or protocol, and an active-low connect output shows the link status. The address width is a parameter (default 10).

Top module: `scan_port_switch`

## Requirements
- R1: While `pTrstN` is low and `bypassN` is high, the block is in its reset condition. `connectN`=1, `sTdoEn`=0 and `pTdoEn`=0, and `sTms`=1 so that the secondary TAP is driven into Test-Logic-Reset. An asserted `pTrstN` has the same effect as power-up.
- R2: `sTck` always equals `pTck`, and `sTrstN` always equals `pTrstN`.
- R3: A frame is received on `pTdi` at rising `pTck` edges and is aligned to the first edge spent in a stable state. The receiver groups the bits into pairs. A pair of two equal bits is a start symbol. Each address bit, MSB first, is sent as the bit followed by its complement. After exactly ADDR_W data pairs, a pair of two equal bits ends the frame. If the address equals `boardAddr` (and `boardAddr` is not reserved), the next 2*ADDR_W falling-edge samples show `pTdoEn`=1 and `connectN`=1. `pTdo` carries `boardAddr` in the same bit-pair code, MSB first. After that the port is ON and `connectN`=0.
- R4: When ON, `sTdo`=`pTdi`, `sTms`=`pTms` and `pTdo`=`sTdi`, all combinationally, with `sTdoEn`=`pTdoEn`=1.
- R5: A frame carrying a non-matching address leaves the port OFF with no acknowledgment. In that state `connectN`=1, `sTdoEn`=0 and `pTdoEn`=0. `sTms` holds the `pTms` level seen at the moment of disconnect.
- R6: The all-ones address disconnects every port, exactly as a mismatch does.
- R7: The all-ones-minus-one address puts every port into the reset condition of R1.
- R8: The all-ones-minus-two address, when received in Pause-DR or Pause-IR, puts the port into MULTICAST. In that mode `connectN`=0, `sTdoEn`=1, `pTdoEn`=0, `sTdo`=`pTdi` and `sTms`=`pTms`. Received in Run-Test/Idle or Test-Logic-Reset, it changes nothing.
- R9: Frames are accepted only while the TAP holds in Test-Logic-Reset, Run-Test/Idle, Pause-DR or Pause-IR. A frame clocked in Shift-DR or Shift-IR changes nothing.
- R10: A malformed frame changes nothing. This covers a data pair with no start symbol, an equal pair after fewer than ADDR_W data pairs, and a data pair beyond the ADDR_W-th.
- R11: While `bypassN` is low, `connectN`=0, `sTdoEn`=`pTdoEn`=1 and the paths of R4 are active, even while `pTrstN` is low. Frames received in that time are ignored.
- R12: A `boardAddr` strapped to one of the three reserved values never matches and never acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pTck | input | 1 | Primary test clock |
| pTrstN | input | 1 | Primary test reset, active low, asynchronous |
| pTms | input | 1 | Primary test mode select |
| pTdi | input | 1 | Primary test data in, also carries address frames |
| pTdo | output | 1 | Primary test data out (return path or acknowledgment) |
| pTdoEn | output | 1 | Drive enable for pTdo |
| bypassN | input | 1 | Forces connection when low |
| boardAddr | input | ADDR_W | Strapped board address |
| connectN | output | 1 | Low while connected |
| sTck | output | 1 | Secondary test clock |
| sTrstN | output | 1 | Secondary test reset |
| sTms | output | 1 | Secondary test mode select |
| sTdi | input | 1 | Secondary test data in (from board chain) |
| sTdo | output | 1 | Secondary test data out (to board chain) |
| sTdoEn | output | 1 | Drive enable for sTdo |

## Verification
A change of link state comes from the rising edge that samples the second bit of a frame's end pair. It is visible at the falling edge that follows, so the bench checks state there, one half-cycle after the frame's last bit. Acknowledgment bit k is due at the k-th falling edge after that edge, and ON is due 2*ADDR_W rising edges later. The bench samples each of these at its own falling edge. The forwarding and bypass paths are combinational, so they are checked 1 ns after their inputs are driven, with no clock edge in between.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  typedef enum logic [3:0] {
    TAP_RESET, TAP_IDLE,
    TAP_SEL_DR, TAP_CAP_DR, TAP_SHIFT_DR, TAP_EX1_DR, TAP_PAUSE_DR, TAP_EX2_DR, TAP_UPD_DR,
    TAP_SEL_IR, TAP_CAP_IR, TAP_SHIFT_IR, TAP_EX1_IR, TAP_PAUSE_IR, TAP_EX2_IR, TAP_UPD_IR
  } tapState_e;

  typedef enum logic [2:0] {
    LINK_RESET, LINK_OFF, LINK_ACK, LINK_ON, LINK_MCAST
  } linkState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic fwdEn;    // forward paths (TMS, TDI) connected
    logic retEn;    // return path (secondary data to primary) connected
    logic ackEn;    // acknowledgment owns the primary data output
    logic ackBit;   // acknowledgment symbol bit
    logic tmsHigh;  // reset condition forces secondary TMS high
  } linkStrobes_t;

  function automatic tapState_e tapStep(input tapState_e s, input logic tms);
    case (s)
      TAP_RESET:    return tms ? TAP_RESET    : TAP_IDLE;
      TAP_IDLE:     return tms ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_DR:   return tms ? TAP_SEL_IR   : TAP_CAP_DR;
      TAP_CAP_DR:   return tms ? TAP_EX1_DR   : TAP_SHIFT_DR;
      TAP_SHIFT_DR: return tms ? TAP_EX1_DR   : TAP_SHIFT_DR;
      TAP_EX1_DR:   return tms ? TAP_UPD_DR   : TAP_PAUSE_DR;
      TAP_PAUSE_DR: return tms ? TAP_EX2_DR   : TAP_PAUSE_DR;
      TAP_EX2_DR:   return tms ? TAP_UPD_DR   : TAP_SHIFT_DR;
      TAP_UPD_DR:   return tms ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_IR:   return tms ? TAP_RESET    : TAP_CAP_IR;
      TAP_CAP_IR:   return tms ? TAP_EX1_IR   : TAP_SHIFT_IR;
      TAP_SHIFT_IR: return tms ? TAP_EX1_IR   : TAP_SHIFT_IR;
      TAP_EX1_IR:   return tms ? TAP_UPD_IR   : TAP_PAUSE_IR;
      TAP_PAUSE_IR: return tms ? TAP_EX2_IR   : TAP_PAUSE_IR;
      TAP_EX2_IR:   return tms ? TAP_UPD_IR   : TAP_SHIFT_IR;
      TAP_UPD_IR:   return tms ? TAP_SEL_DR   : TAP_IDLE;
      default:      return TAP_RESET;
    endcase
  endfunction

endpackage

// File: rtl/sp_link_control.sv
module sp_link_control
  import scan_port_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              pTck,
  input  logic              pTrstN,
  input  logic              pTms,
  input  logic              pTdi,
  input  logic              bypassN,
  input  logic [ADDR_W-1:0] boardAddr,
  output linkStrobes_t      strobes
);

  localparam int CNT_W   = $clog2(ADDR_W + 1);
  localparam int ACK_LEN = 2 * ADDR_W;
  localparam int ACK_W   = $clog2(ACK_LEN);
  localparam logic [ADDR_W-1:0] ADDR_DISC = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] ADDR_RST  = ADDR_DISC - 1'b1;
  localparam logic [ADDR_W-1:0] ADDR_SYNC = ADDR_DISC - 2'd2;

  tapState_e  tapState, tapNext;
  linkState_e linkState;

  logic              rxHalf, rxFirst, rxFramed;
  logic [CNT_W-1:0]  rxCnt;
  logic [ADDR_W-1:0] rxShift;
  logic [ACK_W-1:0]  ackCnt;
  logic [ADDR_W-1:0] ackShift;

  assign tapNext = tapStep(tapState, pTms);

  always_ff @(posedge pTck or negedge pTrstN) begin
    if (!pTrstN) tapState <= TAP_RESET;
    else         tapState <= tapNext;
  end

  logic tapStable, tapPause, rxActive, pairEqual, endSym, strapReserved;

  always_comb begin
    tapPause  = (tapState == TAP_PAUSE_DR) || (tapState == TAP_PAUSE_IR);
    tapStable = tapPause || (tapState == TAP_IDLE) || (tapState == TAP_RESET);
    rxActive  = bypassN && tapStable && (tapNext == tapState) && (linkState != LINK_ACK);
    pairEqual = (rxFirst == pTdi);
    endSym    = rxActive && rxHalf && pairEqual && rxFramed && (rxCnt == CNT_W'(ADDR_W));
    strapReserved = (boardAddr == ADDR_DISC) || (boardAddr == ADDR_RST) || (boardAddr == ADDR_SYNC);
  end

  always_ff @(posedge pTck or negedge pTrstN) begin
    if (!pTrstN) begin
      linkState <= LINK_RESET;
      rxHalf    <= 1'b0;
      rxFirst   <= 1'b0;
      rxFramed  <= 1'b0;
      rxCnt     <= '0;
      rxShift   <= '0;
      ackCnt    <= '0;
      ackShift  <= '0;
    end else if (!bypassN) begin
      rxHalf   <= 1'b0;
      rxFramed <= 1'b0;
      rxCnt    <= '0;
    end else begin
      if (linkState == LINK_ACK) begin
        ackCnt <= ackCnt + 1'b1;
        if (ackCnt[0]) ackShift <= {ackShift[ADDR_W-2:0], 1'b0};
        if (ackCnt == ACK_W'(ACK_LEN - 1)) linkState <= LINK_ON;
      end
      if (!rxActive) begin
        rxHalf   <= 1'b0;
        rxFramed <= 1'b0;
        rxCnt    <= '0;
      end else if (!rxHalf) begin
        rxFirst <= pTdi;
        rxHalf  <= 1'b1;
      end else begin
        rxHalf <= 1'b0;
        if (pairEqual) begin
          rxFramed <= 1'b1;
          rxCnt    <= '0;
          if (endSym) begin
            if (rxShift == ADDR_DISC)      linkState <= LINK_OFF;
            else if (rxShift == ADDR_RST)  linkState <= LINK_RESET;
            else if (rxShift == ADDR_SYNC) begin
              if (tapPause) linkState <= LINK_MCAST;
            end else if (rxShift == boardAddr && !strapReserved) begin
              linkState <= LINK_ACK;
              ackCnt    <= '0;
              ackShift  <= boardAddr;
            end else linkState <= LINK_OFF;
          end
        end else if (rxFramed && rxCnt != CNT_W'(ADDR_W)) begin
          rxShift <= {rxShift[ADDR_W-2:0], rxFirst};
          rxCnt   <= rxCnt + 1'b1;
        end else begin
          rxFramed <= 1'b0;
          rxCnt    <= '0;
        end
      end
    end
  end

  always_comb begin
    strobes.fwdEn   = !bypassN || (linkState == LINK_ON) || (linkState == LINK_MCAST);
    strobes.retEn   = !bypassN || (linkState == LINK_ON);
    strobes.ackEn   = bypassN && (linkState == LINK_ACK);
    strobes.ackBit  = ackShift[ADDR_W-1] ^ ackCnt[0];
    strobes.tmsHigh = bypassN && (linkState == LINK_RESET);
  end

endmodule

// File: rtl/sp_link_datapath.sv
module sp_link_datapath
  import scan_port_pkg::*;
(
  input  logic         pTck,
  input  logic         pTrstN,
  input  logic         pTms,
  input  logic         pTdi,
  input  logic         sTdi,
  input  linkStrobes_t strobes,
  output logic         pTdo,
  output logic         pTdoEn,
  output logic         sTms,
  output logic         sTdo,
  output logic         sTdoEn,
  output logic         connectN
);

  logic holdTms;

  // Last forwarded TMS level, kept for the disconnected state
  always_ff @(posedge pTck or negedge pTrstN) begin
    if (!pTrstN)               holdTms <= 1'b1;
    else if (strobes.fwdEn)    holdTms <= pTms;
    else if (strobes.tmsHigh)  holdTms <= 1'b1;
  end

  always_comb begin
    sTms     = strobes.fwdEn ? pTms : (strobes.tmsHigh ? 1'b1 : holdTms);
    sTdo     = strobes.fwdEn ? pTdi : 1'b0;
    sTdoEn   = strobes.fwdEn;
    pTdo     = strobes.ackEn ? strobes.ackBit : (strobes.retEn ? sTdi : 1'b0);
    pTdoEn   = strobes.ackEn || strobes.retEn;
    connectN = !strobes.fwdEn;
  end

endmodule

// File: rtl/scan_port_switch.sv
module scan_port_switch
  import scan_port_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              pTck,
  input  logic              pTrstN,
  input  logic              pTms,
  input  logic              pTdi,
  output logic              pTdo,
  output logic              pTdoEn,
  input  logic              bypassN,
  input  logic [ADDR_W-1:0] boardAddr,
  output logic              connectN,
  output logic              sTck,
  output logic              sTrstN,
  output logic              sTms,
  input  logic              sTdi,
  output logic              sTdo,
  output logic              sTdoEn
);

  linkStrobes_t strobes;

  assign sTck   = pTck;
  assign sTrstN = pTrstN;

  sp_link_control #(.ADDR_W(ADDR_W)) ctrl_i (
    .pTck(pTck), .pTrstN(pTrstN), .pTms(pTms), .pTdi(pTdi),
    .bypassN(bypassN), .boardAddr(boardAddr), .strobes(strobes)
  );

  sp_link_datapath dp_i (
    .pTck(pTck), .pTrstN(pTrstN), .pTms(pTms), .pTdi(pTdi), .sTdi(sTdi),
    .strobes(strobes), .pTdo(pTdo), .pTdoEn(pTdoEn), .sTms(sTms),
    .sTdo(sTdo), .sTdoEn(sTdoEn), .connectN(connectN)
  );

endmodule

// File: rtl/scan_port_switch_chk.sv
module scan_port_switch_chk (
  input logic pTck,
  input logic pTrstN,
  input logic pTms,
  input logic bypassN,
  input logic connectN,
  input logic pTdoEn,
  input logic sTdoEn,
  input logic sTms
);

  assert_reset_safe_R1: assert property (@(posedge pTck)
    (!pTrstN && bypassN) |-> (connectN && !sTdoEn && !pTdoEn && sTms));

  assert_bypass_links_R11: assert property (@(posedge pTck)
    !bypassN |-> (!connectN && sTdoEn && pTdoEn));

  assert_ack_before_on_R3: assert property (@(posedge pTck) disable iff (!pTrstN)
    (bypassN && $past(bypassN) && $fell(connectN) && pTdoEn) |-> ($past(pTdoEn) && $past(connectN)));

  assert_off_quiet_R5: assert property (@(posedge pTck) disable iff (!pTrstN)
    (connectN && bypassN) |-> !sTdoEn);

  assert_hold_tms_R5: assert property (@(posedge pTck) disable iff (!pTrstN)
    (connectN && $past(connectN) && bypassN && $past(bypassN)) |-> ($stable(sTms) || sTms));

  assert_mcast_listen_R8: assert property (@(posedge pTck) disable iff (!pTrstN)
    (!connectN && !pTdoEn) |-> (sTdoEn && sTms == pTms));

endmodule

bind scan_port_switch scan_port_switch_chk chk_i (
  .pTck(pTck), .pTrstN(pTrstN), .pTms(pTms), .bypassN(bypassN),
  .connectN(connectN), .pTdoEn(pTdoEn), .sTdoEn(sTdoEn), .sTms(sTms)
);

// File: tb/scan_port_switch_tb_top.sv
`timescale 1ns/1ps
module scan_port_switch_tb_top;

  localparam int W = 4;
  localparam int RES_LO = (1 << W) - 3;  // lowest reserved value
  localparam int A_DISC = (1 << W) - 1;
  localparam int A_RST  = (1 << W) - 2;
  localparam int A_SYNC = (1 << W) - 3;

  logic pTck = 1'b0;
  logic pTrstN, pTms, pTdi, bypassN, sTdi;
  logic [W-1:0] boardAddr;
  logic pTdo, pTdoEn, connectN, sTck, sTrstN, sTms, sTdo, sTdoEn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 pTck = ~pTck;

  scan_port_switch #(.ADDR_W(W)) dut_i (
    .pTck(pTck), .pTrstN(pTrstN), .pTms(pTms), .pTdi(pTdi), .pTdo(pTdo),
    .pTdoEn(pTdoEn), .bypassN(bypassN), .boardAddr(boardAddr),
    .connectN(connectN), .sTck(sTck), .sTrstN(sTrstN), .sTms(sTms),
    .sTdi(sTdi), .sTdo(sTdo), .sTdoEn(sTdoEn)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic tms, input logic tdi);
    pTms = tms; pTdi = tdi;
    @(posedge pTck);
    @(negedge pTck);
  endtask

  task automatic doReset();
    pTrstN = 1'b0;
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    pTrstN = 1'b1;
  endtask

  task automatic toIdle();      tick(0,0); endtask
  task automatic idleToPauseDr(); tick(1,0); tick(0,0); tick(1,0); tick(0,0); endtask
  task automatic idleToPauseIr(); tick(1,0); tick(1,0); tick(0,0); tick(1,0); tick(0,0); endtask
  task automatic pauseToIdle(); tick(1,0); tick(1,0); tick(0,0); endtask
  task automatic idleToShiftDr(); tick(1,0); tick(0,0); tick(0,0); endtask
  task automatic shiftToIdle(); tick(1,0); tick(1,0); tick(0,0); endtask
  task automatic idleToTlr();   tick(1,0); tick(1,0); tick(1,0); endtask

  task automatic sendFrame(input int addr, input logic tms);
    tick(tms, 1'b0); tick(tms, 1'b0);
    for (int b = W - 1; b >= 0; b--) begin
      tick(tms, addr[b]);
      tick(tms, ~addr[b]);
    end
    tick(tms, 1'b0); tick(tms, 1'b0);
  endtask

  // Checks the acknowledgment that follows a matching frame, then ON
  task automatic checkAck(input int a, input logic tms, input string req);
    for (int i = 0; i < 2 * W; i++) begin
      chkEq({req, " ack enable"}, pTdoEn, 1);
      chkEq({req, " ack keeps link off"}, connectN, 1);
      chkEq({req, " ack bit"}, pTdo, ((a >> (W - 1 - i / 2)) & 1) ^ (i % 2));
      tick(tms, 1'b0);
    end
    chkEq({req, " on after ack"}, connectN, 0);
  endtask

  initial begin
    pTrstN = 1'b0; pTms = 1'b1; pTdi = 1'b0; bypassN = 1'b1; sTdi = 1'b0;
    boardAddr = W'(5);
    @(negedge pTck);

    // R1: reset condition
    doReset();
    pTrstN = 1'b0; #1;
    chkEq("R1 connectN", connectN, 1);
    chkEq("R1 sTdoEn", sTdoEn, 0);
    chkEq("R1 pTdoEn", pTdoEn, 0);
    chkEq("R1 sTms", sTms, 1);
    // R2: clock and reset pass-through
    chkEq("R2 sTrstN low", sTrstN, 0);
    chkEq("R2 sTck low", sTck, pTck);
    pTrstN = 1'b1; #1;
    chkEq("R2 sTrstN high", sTrstN, 1);
    @(posedge pTck); #2;
    chkEq("R2 sTck high", sTck, 1);
    @(negedge pTck);

    // R3/R12: near-exhaustive sweep of straps against sent addresses, in Run-Test/Idle
    for (int bi = 0; bi < 6; bi++) begin
      int b;
      case (bi)
        0: b = 0; 1: b = 5; 2: b = RES_LO - 1;
        3: b = A_SYNC; 4: b = A_RST; default: b = A_DISC;
      endcase
      for (int s = 0; s < (1 << W); s++) begin
        boardAddr = W'(b);
        doReset();
        toIdle();
        sendFrame(s, 1'b0);
        if (s == b && b < RES_LO) begin
          checkAck(b, 1'b0, "R3");
        end else begin
          chkEq((b >= RES_LO) ? "R12 no ack" : "R5 no ack", pTdoEn, 0);
          chkEq((b >= RES_LO) ? "R12 link off" : "R5 link off", connectN, 1);
          chkEq("R5 sTdoEn off", sTdoEn, 0);
        end
      end
    end

    // R4: forwarding while ON
    boardAddr = W'(5);
    doReset(); toIdle(); sendFrame(5, 1'b0); checkAck(5, 1'b0, "R3");
    for (int v = 0; v < 8; v++) begin
      pTdi = v[0]; sTdi = v[1]; pTms = v[2]; #1;
      chkEq("R4 sTdo", sTdo, v[0]);
      chkEq("R4 pTdo", pTdo, v[1]);
      chkEq("R4 sTms", sTms, v[2]);
      chkEq("R4 enables", {30'd0, sTdoEn, pTdoEn}, 3);
    end
    pTms = 1'b0; pTdi = 1'b0; sTdi = 1'b0;

    // R9: disconnect frame clocked in Shift-DR is ignored
    idleToShiftDr(); sendFrame(A_DISC, 1'b0); shiftToIdle();
    chkEq("R9 shift frame ignored", connectN, 0);

    // R10: malformed frames
    tick(0,0); tick(0,0);
    for (int k = 0; k < 3; k++) begin tick(0,1); tick(0,0); end
    tick(0,0); tick(0,0);
    chkEq("R10 truncated frame", connectN, 0);
    tick(0,0); tick(0,0);
    for (int k = 0; k < W + 1; k++) begin tick(0,1); tick(0,0); end
    tick(0,0); tick(0,0);
    chkEq("R10 overlong frame", connectN, 0);
    idleToPauseDr(); pauseToIdle();
    for (int k = 0; k < W; k++) begin tick(0,1); tick(0,0); end
    tick(0,0); tick(0,0);
    chkEq("R10 frame without start", connectN, 0);
    chkEq("R10 still returning", pTdoEn, 1);

    // R5/R6: disconnect address, TMS hold
    sendFrame(A_DISC, 1'b0);
    chkEq("R6 disconnect", connectN, 1);
    chkEq("R6 sTdoEn", sTdoEn, 0);
    chkEq("R6 pTdoEn", pTdoEn, 0);
    chkEq("R5 sTms held low", sTms, 0);
    tick(1,0);
    chkEq("R5 sTms ignores pTms", sTms, 0);
    tick(1,0); tick(1,0);  // now Test-Logic-Reset
    sendFrame(3, 1'b1);
    chkEq("R5 mismatch in TLR", connectN, 1);
    chkEq("R5 sTms still held", sTms, 0);
    sendFrame(5, 1'b1);
    checkAck(5, 1'b1, "R9 TLR accepted");
    chkEq("R4 sTms follows in TLR", sTms, 1);

    // R7: reset address
    toIdle();
    sendFrame(A_RST, 1'b0);
    chkEq("R7 link off", connectN, 1);
    chkEq("R7 sTms forced high", sTms, 1);
    chkEq("R7 pTdoEn", pTdoEn, 0);

    // R8: multicast
    idleToPauseDr(); sendFrame(A_SYNC, 1'b0);
    chkEq("R8 pause-DR connect", connectN, 0);
    chkEq("R8 pTdoEn off", pTdoEn, 0);
    chkEq("R8 sTdoEn on", sTdoEn, 1);
    pTdi = 1'b1; sTdi = 1'b1; #1;
    chkEq("R8 sTdo forwards", sTdo, 1);
    chkEq("R8 sTms forwards", sTms, 0);
    pTdi = 1'b0; sTdi = 1'b0;
    pauseToIdle(); sendFrame(A_DISC, 1'b0);
    chkEq("R6 leaves multicast", connectN, 1);
    idleToPauseIr(); sendFrame(A_SYNC, 1'b0);
    chkEq("R8 pause-IR connect", connectN, 0);
    pauseToIdle(); sendFrame(A_DISC, 1'b0);
    sendFrame(A_SYNC, 1'b0);
    chkEq("R8 idle ignored", connectN, 1);
    idleToTlr(); sendFrame(A_SYNC, 1'b1);
    chkEq("R8 TLR ignored", connectN, 1);

    // R11: bypass
    pTrstN = 1'b0; bypassN = 1'b0; pTms = 1'b0; sTdi = 1'b1; #1;
    chkEq("R11 connect in reset", connectN, 0);
    chkEq("R11 sTdoEn", sTdoEn, 1);
    chkEq("R11 pTdoEn", pTdoEn, 1);
    chkEq("R11 sTms follows", sTms, 0);
    chkEq("R11 pTdo returns", pTdo, 1);
    sTdi = 1'b0;
    tick(1,0); pTrstN = 1'b1;
    toIdle(); sendFrame(5, 1'b0);
    chkEq("R11 still connected", connectN, 0);
    bypassN = 1'b1; #1;
    chkEq("R11 frame ignored", connectN, 1);
    chkEq("R11 no ack", pTdoEn, 0);
    tick(0,0);
    chkEq("R11 no late ack", pTdoEn, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge pTck);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule